// File: doc/BRIEF.md
# Serial Memory Read Target

This block is a two-wire bus target that sits in front of a 32768-byte memory and serves the read half of a serial EEPROM. A controller addresses it with a fixed 7-bit device address. The block acknowledges that address and then streams bytes out of the memory, starting at a persistent 15-bit location pointer. The pointer survives from one transaction to the next, so a plain read carries on where the previous one stopped. The pointer steps up by one for every byte fetched and rolls over from the top address to zero.

To start somewhere else, the controller sends a short write frame that carries only a two-byte location, high byte first, with the top bit of the high byte ignored. It then issues a repeated START and a read. Every byte the controller acknowledges is followed by the next one. A not-acknowledged byte followed by STOP ends the read. The memory side is a synchronous read port: a one-cycle read strobe with the address, and the data valid on the next cycle. SCL and SDA are sampled through a synchronizer on the system clock. SDA is driven as an open-drain pad: the line is pulled low only when the output enable is set and the output value is 0.

The state machine has these states. ST_IDLE is entered after reset and on STOP. ST_DEV receives the device byte. ST_DEV_ACK drives the address acknowledge. ST_HI and ST_HI_ACK receive and acknowledge the high location byte. ST_LO and ST_LO_ACK do the same for the low location byte, and ST_LO_ACK loads the pointer. ST_TX shifts a data byte out, most significant bit first. ST_RX_ACK samples the controller's acknowledge. ST_SKIP leaves the bus alone until the next START or STOP.

The transitions are as follows. A START moves any state to ST_DEV, and a STOP moves any state to ST_IDLE. At the SCL fall after the eighth device bit, ST_DEV goes to ST_DEV_ACK if the address matches and to ST_SKIP if it does not. ST_DEV_ACK goes to ST_TX for a read or to ST_HI for a write. The flow then runs ST_HI to ST_HI_ACK to ST_LO to ST_LO_ACK to ST_SKIP. ST_TX goes to ST_RX_ACK after eight bits. ST_RX_ACK goes back to ST_TX on an acknowledge, or to ST_SKIP when the byte is not acknowledged.

Top module: `serial_mem_reader`

## Requirements
- R1: After reset SDA is released (no pull-down), no memory read is issued, and the location pointer is 0.
- R2: After a START and device byte 0x50 with R/W=1 (byte 0xA1), the target pulls SDA low in the 9th clock, then sends the byte at the pointer, MSB first.
- R3: For a device byte whose address differs from 0x50, the target does not acknowledge and keeps SDA released until the next START, and the pointer is unchanged.
- R4: A write frame (byte 0xA0) followed by a high byte (bit 7 ignored) and a low byte is acknowledged on each byte, and loads the pointer with {high[6:0], low}. After a repeated START and a read, the first byte comes from that location.
- R5: Each data byte the controller acknowledges (SDA low in its 9th clock) is followed by the byte at the next location.
- R6: The pointer wraps from 0x7FFF to 0x0000 during a sequential read.
- R7: The pointer persists across transactions: a read with no location frame starts just after the last byte fetched.
- R8: A not-acknowledged data byte ends transmission. The target releases SDA, and after STOP it stays released.
- R9: The level the target forces on SDA changes only while SCL is low.
- R10: mem_rd is a one-cycle pulse, and mem_addr advances by exactly one (mod 2^15) in the cycle after each pulse.
- R11: A START in the middle of a byte restarts the state machine at device-address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | SDA pad drive enable |
| sda_o | output | 1 | SDA pad value (line pulled low when enabled and 0) |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 15 | Memory read address (the location pointer) |
| mem_rdata | input | 8 | Memory read data, valid the cycle after mem_rd |

## Verification
Reads are tried as a single byte from the reset pointer, as a second plain read, as a selective read to a mid-memory location followed by a sequential burst, and as a selective read just below the top of memory. Together these separate a pointer that persists from one that resets, a load of {high[6:0], low} from one that keeps the ignored bit, and wrap-around from stopping at the top. A frame to a foreign address, followed by a plain read, shows that a mismatch neither drives the bus nor moves the pointer. A START inserted in the middle of a byte shows that the state machine restarts cleanly.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_HI,
        ST_HI_ACK,
        ST_LO,
        ST_LO_ACK,
        ST_TX,
        ST_RX_ACK,
        ST_SKIP
    } rd_state_t;
endpackage

// File: rtl/i2cr_line_sync.sv
module i2cr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cr_addr_ctr.sv
module i2cr_addr_ctr #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         inc,
    output logic [W-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    value <= '0;
        else if (load) value <= load_val;
        else if (inc)  value <= value + 1'b1;
    end
endmodule

// File: rtl/serial_mem_reader.sv
module serial_mem_reader
    import i2cr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         ADDR_W      = 15,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              sda_o,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata
);
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam int HI_W   = ADDR_W - BYTE_W;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    rd_state_t state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sr, tx_sr, hi_byte;
    logic              is_read, fetch_pend;
    logic              ctr_load;
    logic [ADDR_W-1:0] ctr_val;
    logic              bus_evt, byte_done, dev_match;

    i2cr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cr_addr_ctr #(.W(ADDR_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(ctr_load),
        .load_val({hi_byte[HI_W-1:0], rx_sr}), .inc(mem_rd), .value(ctr_val)
    );

    assign bus_evt   = start_det | stop_det;
    assign byte_done = scl_fall && (bit_cnt == CNT_W'(BYTE_W));
    assign dev_match = (rx_sr[7:1] == DEV_ADDR);
    assign mem_addr  = ctr_val;

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            rx_sr      <= '0;
            tx_sr      <= '1;
            hi_byte    <= '0;
            is_read    <= 1'b0;
            fetch_pend <= 1'b0;
        end else begin
            fetch_pend <= mem_rd;
            if (fetch_pend) tx_sr <= mem_rdata;
            if (start_det) begin
                state   <= ST_DEV;
                bit_cnt <= '0;
            end else if (stop_det) begin
                state   <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE, ST_SKIP: ;
                    ST_DEV, ST_HI, ST_LO: begin
                        if (scl_rise) begin
                            rx_sr   <= {rx_sr[6:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (byte_done) begin
                            bit_cnt <= '0;
                            if (state == ST_DEV) begin
                                is_read <= rx_sr[0];
                                state   <= dev_match ? ST_DEV_ACK : ST_SKIP;
                            end else if (state == ST_HI) begin
                                hi_byte <= rx_sr;
                                state   <= ST_HI_ACK;
                            end else begin
                                state   <= ST_LO_ACK;
                            end
                        end
                    end
                    ST_DEV_ACK: if (scl_fall) state <= is_read ? ST_TX : ST_HI;
                    ST_HI_ACK:  if (scl_fall) state <= ST_LO;
                    ST_LO_ACK:  if (scl_fall) state <= ST_SKIP;
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                                state   <= ST_RX_ACK;
                                bit_cnt <= '0;
                            end else begin
                                tx_sr   <= {tx_sr[6:0], 1'b1};
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_rise) is_read <= ~sda_s;
                        else if (scl_fall) state <= is_read ? ST_TX : ST_SKIP;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        sda_oe   = 1'b0;
        sda_o    = 1'b1;
        mem_rd   = 1'b0;
        ctr_load = 1'b0;
        unique case (state)
            ST_DEV: mem_rd = !bus_evt && byte_done && dev_match && rx_sr[0];
            ST_DEV_ACK, ST_HI_ACK: begin
                sda_oe = 1'b1;
                sda_o  = 1'b0;
            end
            ST_LO_ACK: begin
                sda_oe   = 1'b1;
                sda_o    = 1'b0;
                ctr_load = !bus_evt && scl_fall;
            end
            ST_TX: begin
                sda_oe = 1'b1;
                sda_o  = tx_sr[7];
            end
            ST_RX_ACK: mem_rd = !bus_evt && scl_rise && !sda_s;
            default: ;
        endcase
    end
endmodule

// File: rtl/serial_mem_reader_chk.sv
module serial_mem_reader_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              sda_o,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr
);
    logic pull;
    assign pull = sda_oe & ~sda_o;

    assert_sda_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(pull));

    assert_drive_in_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull) |-> !scl_i);

    assert_rd_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    assert_addr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));
endmodule

bind serial_mem_reader serial_mem_reader_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .sda_o(sda_o),
    .mem_rd(mem_rd), .mem_addr(mem_addr)
);

// File: tb/tb_serial_mem_reader.sv
`timescale 1ns/1ps
module tb_serial_mem_reader;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic sda_oe, sda_o, mem_rd;
    logic [14:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic scl, sda;
    int checks = 0, fails = 0;
    int r9_viol = 0, r10_viol = 0;
    logic [14:0] exp_ptr = '0;
    logic prev_scl = 1'b1, prev_pull = 1'b0, prev_rd = 1'b0;

    always #10 clk = ~clk;

    assign scl = ~m_scl_low;
    assign sda = ~(m_sda_low | (sda_oe & ~sda_o));

    serial_mem_reader dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .sda_oe(sda_oe), .sda_o(sda_o), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] mval(input logic [14:0] a);
        return a[7:0] ^ {a[14:8], 1'b1} ^ 8'h3C;
    endfunction

    always_ff @(posedge clk) if (mem_rd) mem_rdata <= mval(mem_addr);

    always @(negedge clk) begin
        if (rst_n) begin
            if (scl && prev_scl && ((sda_oe & ~sda_o) != prev_pull)) r9_viol++;
            if (mem_rd && prev_rd) r10_viol++;
        end
        prev_scl  = scl;
        prev_pull = sda_oe & ~sda_o;
        prev_rd   = mem_rd;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic q_wait(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        m_sda_low = 1'b0; q_wait();
        m_scl_low = 1'b0; q_wait();
        m_sda_low = 1'b1; q_wait();
        m_scl_low = 1'b1; q_wait();
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; q_wait();
        m_scl_low = 1'b0; q_wait();
        m_sda_low = 1'b0; q_wait();
    endtask

    task automatic bit_cycle(input logic drive, output logic seen);
        m_sda_low = ~drive; q_wait();
        m_scl_low = 1'b0;   q_wait();
        seen = sda;         q_wait();
        m_scl_low = 1'b1;   q_wait();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
        bit_cycle(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, s);
            b[i] = s;
        end
        bit_cycle(~give_ack, s);
    endtask

    // Plain read of n bytes, checked against the model pointer
    task automatic plain_read(input string req, input int n);
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte(8'hA1, ack);
        check({req, " ack"}, ack, 1'b1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, d);
            check({req, " data"}, d, mval(exp_ptr));
            exp_ptr = exp_ptr + 1'b1;
        end
        bus_stop();
        check("R8 released after stop", sda, 1'b1);
    endtask

    task automatic selective_read(input string req, input logic [7:0] hi, input logic [7:0] lo, input int n);
        logic ack;
        bus_start();
        send_byte(8'hA0, ack); check("R4 write dev ack", ack, 1'b1);
        send_byte(hi, ack);    check("R4 hi ack", ack, 1'b1);
        send_byte(lo, ack);    check("R4 lo ack", ack, 1'b1);
        exp_ptr = {hi[6:0], lo};
        plain_read(req, n);
    endtask

    task automatic t_reset();
        check("R1 sda released", sda, 1'b1);
        check("R1 no read", mem_rd, 1'b0);
        check("R1 pointer zero", mem_addr, 15'd0);
    endtask

    task automatic t_mismatch();
        logic ack;
        logic [7:0] d;
        bus_start();
        send_byte(8'hA3, ack);
        check("R3 no ack", ack, 1'b0);
        recv_byte(1'b0, d);
        check("R3 bus untouched", d, 8'hFF);
        bus_stop();
        plain_read("R3 pointer unchanged", 1);
    endtask

    task automatic t_restart_mid_byte();
        logic s;
        bus_start();
        for (int i = 0; i < 4; i++) bit_cycle(1'b0, s);
        plain_read("R11 restart mid byte", 1);
    endtask

    initial begin
        m_sda_low = 1'b0;
        m_scl_low = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        plain_read("R2 first read", 1);
        plain_read("R7 persistent pointer", 1);
        selective_read("R5 sequential from loaded", 8'h92, 8'h34, 4);
        selective_read("R6 wrap", 8'h7F, 8'hFE, 3);
        check("R6 pointer after wrap", mem_addr, 15'd1);
        t_mismatch();
        t_restart_mid_byte();
        check("R9 sda held while scl high", r9_viol, 0);
        check("R10 single-cycle strobe", r10_viol, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule